// File: doc/BRIEF.md
# Byte-Framed Word Serializer

This block turns a parallel word into one serial bit stream for a modelled transceiver link. The word carries a data byte per lane and a valid flag per lane. On the line, every byte becomes a fixed symbol of ten bits: the eight data bits, least significant first, followed by two copies of that lane's flag. The four symbols of a 32-bit word are sent lane 0 first and make a 40-bit frame.

The block runs on a line-rate bit clock. It divides that clock by the frame length to make the word-rate clock for the user side, together with a transmit reset. At the nominal figures, a 6.25 Gbit/s line gives a 156.25 MHz word clock, so one frame fills exactly one word period. User logic launches a word and its flags on a rising edge of the word clock. The serializer captures them on the next rising edge and shifts them out during the following word period.

A three-state controller sets the start-up order. HOLD is the state while the asynchronous reset is asserted. The transition RELEASE leads to WAKE on the first bit-clock edge after reset is removed. In WAKE the word clock runs but the transmit reset stays high and the line is idle. The transition ARM leads to RUN on the next word boundary, where the first word is loaded. RUN stays in RUN until reset is asserted again. Reset moves any state straight back to HOLD.

Top module: `serw_link`

## Requirements
- R1: While `rst` is high, `word_rst` is 1, `line_out` is 0 and `word_clk` is 0, whatever the data and flag inputs are.
- R2: After reset release, `word_clk` has a period of 40 bit-clock cycles. It is high for the first 20 cycles of each frame and low for the last 20. It rises on the same bit-clock edge at which a frame starts.
- R3: For the first word period after reset release (the WAKE state), `word_rst` stays 1 and `line_out` stays 0 even when the inputs are non-zero. `word_rst` falls on the second rising edge of `word_clk`.
- R4: While running, the data and flags present at a rising edge of `word_clk` are sent in the 40 bit cycles that follow that edge, one line bit per cycle, starting with line bit 0 in the first cycle.
- R5: Lanes are sent in order. Line bits 10·b to 10·b+9 belong to lane b, where lane b is `word_data[8b+7:8b]` and `word_flags[b]`. Lane 0 goes first.
- R6: Within lane b, line bit 10·b+k for k = 0..7 equals `word_data[8b+k]` (LSb first). Line bits 10·b+8 and 10·b+9 both equal `word_flags[b]`.
- R7: A word is sent even when its flags are 0. Its data bits appear unchanged and its flag bits are 0.
- R8: Asserting `rst` in the middle of a frame forces `line_out` to 0 and `word_rst` to 1 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Line-rate bit clock |
| rst | input | 1 | Asynchronous active-high reset |
| word_data | input | 32 | Parallel word, lane b in bits 8b+7:8b |
| word_flags | input | 4 | Per-lane valid flag |
| word_clk | output | 1 | Word-rate clock toward user logic (bit_clk / 40) |
| word_rst | output | 1 | Transmit-side reset toward user logic |
| line_out | output | 1 | Serial line |

## Verification
Two situations are hardest to reach from the ports. The first is the WAKE word, where the word clock is already running but nothing may reach the line. The second is a reset that lands in the middle of a frame. The stimulus drives all-ones data and flags during reset and through WAKE, so any early load or leftover shift bit shows up on the line. It also re-asserts reset partway through a random frame, then checks that the line drops at once and that a fresh WAKE period follows. Directed words separate byte order from bit order: lanes hold distinct values and flag patterns alternate. Seeded random words then cover the rest.

// File: rtl/serw_pkg.sv
package serw_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAKE = 2'd1,
        ST_RUN  = 2'd2
    } link_state_e;
endpackage

// File: rtl/serw_word_divider.sv
module serw_word_divider #(
    parameter int FRAME_W = 40,
    localparam int CNT_W  = $clog2(FRAME_W),
    localparam int HALF   = FRAME_W / 2
) (
    input  logic bit_clk,
    input  logic rst,
    output logic word_edge,
    output logic word_clk
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    assign word_edge = (cnt_q == CNT_W'(FRAME_W - 1));
    assign cnt_d     = word_edge ? '0 : cnt_q + 1'b1;

    always_ff @(posedge bit_clk or posedge rst) begin
        if (rst) begin
            cnt_q    <= CNT_W'(FRAME_W - 1);
            word_clk <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            word_clk <= (cnt_d < CNT_W'(HALF));
        end
    end
endmodule

// File: rtl/serw_frame_pack.sv
module serw_frame_pack #(
    parameter int LANES       = 4,
    parameter int BYTE_W      = 8,
    parameter int FLAG_COPIES = 2,
    localparam int SYM_W      = BYTE_W + FLAG_COPIES,
    localparam int FRAME_W    = LANES * SYM_W
) (
    input  logic [LANES*BYTE_W-1:0] data_i,
    input  logic [LANES-1:0]        flags_i,
    output logic [FRAME_W-1:0]      frame_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign frame_o[l*SYM_W +: BYTE_W]               = data_i[l*BYTE_W +: BYTE_W];
        assign frame_o[l*SYM_W + BYTE_W +: FLAG_COPIES] = {FLAG_COPIES{flags_i[l]}};
    end
endmodule

// File: rtl/serw_shifter.sv
module serw_shifter #(
    parameter int FRAME_W = 40
) (
    input  logic               bit_clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               line_o
);
    logic [FRAME_W-1:0] shift_q;

    always_ff @(posedge bit_clk or posedge rst) begin
        if (rst) begin
            shift_q <= '0;
        end else if (load) begin
            shift_q <= frame_i;
        end else begin
            shift_q <= shift_q >> 1;
        end
    end

    assign line_o = shift_q[0];
endmodule

// File: rtl/serw_link.sv
module serw_link #(
    parameter int DATA_W      = 32,
    parameter int BYTE_W      = 8,
    parameter int FLAG_COPIES = 2,
    localparam int LANES      = DATA_W / BYTE_W,
    localparam int SYM_W      = BYTE_W + FLAG_COPIES,
    localparam int FRAME_W    = LANES * SYM_W
) (
    input  logic              bit_clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] word_data,
    input  logic [LANES-1:0]  word_flags,
    output logic              word_clk,
    output logic              word_rst,
    output logic              line_out
);
    import serw_pkg::*;

    link_state_e        state_q;
    link_state_e        state_d;
    logic               word_edge;
    logic               load;
    logic [FRAME_W-1:0] frame;

    serw_word_divider #(.FRAME_W(FRAME_W)) u_div (
        .bit_clk   (bit_clk),
        .rst       (rst),
        .word_edge (word_edge),
        .word_clk  (word_clk)
    );

    serw_frame_pack #(
        .LANES       (LANES),
        .BYTE_W      (BYTE_W),
        .FLAG_COPIES (FLAG_COPIES)
    ) u_pack (
        .data_i  (word_data),
        .flags_i (word_flags),
        .frame_o (frame)
    );

    serw_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .bit_clk (bit_clk),
        .rst     (rst),
        .load    (load),
        .frame_i (frame),
        .line_o  (line_out)
    );

    // State register
    always_ff @(posedge bit_clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: RELEASE (HOLD->WAKE), ARM (WAKE->RUN at word boundary)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = ST_WAKE;
            ST_WAKE: if (word_edge) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_HOLD;
        endcase
    end

    // Outputs
    always_comb begin
        word_rst = 1'b1;
        load     = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                word_rst = 1'b1;
                load     = 1'b0;
            end
            ST_WAKE: begin
                word_rst = 1'b1;
                load     = word_edge;
            end
            ST_RUN: begin
                word_rst = 1'b0;
                load     = word_edge;
            end
            default: begin
                word_rst = 1'b1;
                load     = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/serw_link_chk.sv
module serw_link_chk #(
    parameter int DATA_W      = 32,
    parameter int BYTE_W      = 8,
    parameter int FLAG_COPIES = 2,
    localparam int LANES      = DATA_W / BYTE_W,
    localparam int SYM_W      = BYTE_W + FLAG_COPIES,
    localparam int FRAME_W    = LANES * SYM_W,
    localparam int HALF       = FRAME_W / 2,
    localparam int IDX_W      = $clog2(FRAME_W + 1)
) (
    input logic              bit_clk,
    input logic              rst,
    input logic [DATA_W-1:0] word_data,
    input logic [LANES-1:0]  word_flags,
    input logic              word_clk,
    input logic              word_rst,
    input logic              line_out
);
    logic             wclk_d;
    logic             seen_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] cur_idx;
    logic [LANES-1:0] flags_d;
    logic [LANES-1:0] flags_cap;
    logic             rise;

    assign rise    = word_clk && !wclk_d;
    assign cur_idx = rise ? '0 : idx_q;

    always_ff @(posedge bit_clk or posedge rst) begin
        if (rst) begin
            wclk_d    <= 1'b0;
            seen_q    <= 1'b0;
            idx_q     <= '0;
            flags_d   <= '0;
            flags_cap <= '0;
        end else begin
            wclk_d  <= word_clk;
            flags_d <= word_flags;
            if (rise) begin
                idx_q     <= IDX_W'(1);
                seen_q    <= 1'b1;
                flags_cap <= flags_d;
            end else if (idx_q < IDX_W'(FRAME_W)) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge bit_clk)
        rst |-> (word_rst && !line_out && !word_clk));

    assert_period_R2: assert property (@(posedge bit_clk) disable iff (rst)
        (rise && seen_q) |-> (idx_q == IDX_W'(FRAME_W)));

    assert_high_half_R2: assert property (@(posedge bit_clk) disable iff (rst)
        (seen_q && !rise && idx_q < IDX_W'(HALF)) |-> word_clk);

    assert_low_half_R2: assert property (@(posedge bit_clk) disable iff (rst)
        (seen_q && idx_q >= IDX_W'(HALF) && idx_q < IDX_W'(FRAME_W)) |-> !word_clk);

    assert_release_edge_R3: assert property (@(posedge bit_clk) disable iff (rst)
        $fell(word_rst) |-> rise);

    assert_idle_line_R3: assert property (@(posedge bit_clk) disable iff (rst)
        word_rst |-> !line_out);

    assert_first_bit_R4: assert property (@(posedge bit_clk) disable iff (rst)
        (rise && !word_rst) |-> (line_out == $past(word_data[0])));

    assert_flag_bits_R6: assert property (@(posedge bit_clk) disable iff (rst)
        (seen_q && !word_rst && cur_idx < IDX_W'(FRAME_W) && (cur_idx % SYM_W) >= BYTE_W)
        |-> (line_out == flags_cap[cur_idx / SYM_W]));
endmodule

bind serw_link serw_link_chk #(
    .DATA_W      (DATA_W),
    .BYTE_W      (BYTE_W),
    .FLAG_COPIES (FLAG_COPIES)
) u_chk (
    .bit_clk    (bit_clk),
    .rst        (rst),
    .word_data  (word_data),
    .word_flags (word_flags),
    .word_clk   (word_clk),
    .word_rst   (word_rst),
    .line_out   (line_out)
);

// File: tb/tb_serw_link.sv
module tb_serw_link;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] data = '0;
    logic [3:0]  flags = '0;
    logic        wclk;
    logic        wrst;
    logic        line;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_d = '0;
    logic [3:0]  exp_c = '0;

    always #5 clk = ~clk;

    serw_link dut (
        .bit_clk    (clk),
        .rst        (rst),
        .word_data  (data),
        .word_flags (flags),
        .word_clk   (wclk),
        .word_rst   (wrst),
        .line_out   (line)
    );

    function automatic logic [39:0] frame_of(input logic [31:0] d, input logic [3:0] c);
        logic [39:0] f;
        for (int i = 0; i < 40; i++) begin
            if ((i % 10) < 8) f[i] = d[(i / 10) * 8 + (i % 10)];
            else              f[i] = c[i / 10];
        end
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // WAKE word: line idle and reset high, with nd/nc presented meanwhile
    task automatic wake_word(input logic [31:0] nd, input logic [3:0] nc);
        bit idle_ok = 1'b1;
        @(posedge wclk);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (line !== 1'b0 || wrst !== 1'b1) idle_ok = 1'b0;
            if (i == 0) begin data = nd; flags = nc; end
        end
        check(idle_ok, "R3 wake word idle", {62'd0, wrst, line}, 64'h2);
        exp_d = nd;
        exp_c = nc;
    endtask

    // Collect one frame (for exp_d/exp_c) while presenting the next word
    task automatic run_word(input logic [31:0] nd, input logic [3:0] nc, input string req);
        logic [39:0] got;
        bit clk_ok = 1'b1;
        bit rst_ok = 1'b1;
        @(posedge wclk);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            got[i] = line;
            if (wclk !== (i < 20)) clk_ok = 1'b0;
            if (wrst !== 1'b0) rst_ok = 1'b0;
            if (i == 0) begin data = nd; flags = nc; end
        end
        check(got === frame_of(exp_d, exp_c), req, {24'd0, got}, {24'd0, frame_of(exp_d, exp_c)});
        check(clk_ok, "R2 word clock shape", {63'd0, clk_ok}, 64'd1);
        check(rst_ok, "R3 word_rst low while running", {63'd0, rst_ok}, 64'd1);
        exp_d = nd;
        exp_c = nc;
    endtask

    initial begin
        void'($urandom(32'd1234));
        data  = 32'hFFFF_FFFF;
        flags = 4'hF;
        repeat (4) @(negedge clk);
        check(wrst === 1'b1, "R1 word_rst in reset", {63'd0, wrst}, 64'd1);
        check(line === 1'b0, "R1 line in reset", {63'd0, line}, 64'd0);
        check(wclk === 1'b0, "R1 word_clk in reset", {63'd0, wclk}, 64'd0);
        rst = 1'b0;

        wake_word(32'h0000_0000, 4'h0);
        run_word(32'hFFFF_FFFF, 4'hF, "R7 all-zero word with flags clear");
        run_word(32'h0403_0201, 4'b0101, "R6 all-ones word with flags set");
        run_word(32'h0000_0080, 4'b1000, "R5 lane order distinct bytes");
        run_word(32'h1234_5678, 4'h0, "R6 single MSb and top flag");
        run_word(32'hA5C3_3C5A, 4'b1010, "R7 data intact with flags clear");
        for (int n = 0; n < 30; n++) begin
            run_word($urandom, 4'($urandom), "R4 random word");
        end

        // Mid-frame reset (R8), then a fresh WAKE period (R3)
        @(posedge wclk);
        repeat (13) @(negedge clk);
        rst   = 1'b1;
        data  = 32'hFFFF_FFFF;
        flags = 4'hF;
        #1;
        check(line === 1'b0 && wrst === 1'b1, "R8 immediate reset mid-frame", {62'd0, wrst, line}, 64'h2);
        repeat (3) @(negedge clk);
        check(line === 1'b0 && wrst === 1'b1 && wclk === 1'b0, "R1 held in reset",
              {61'd0, wclk, wrst, line}, 64'h2);
        rst = 1'b0;
        wake_word(32'hCAFE_F00D, 4'b0110);
        run_word(32'h8000_0001, 4'b0001, "R5 first word after re-release");
        for (int n = 0; n < 8; n++) begin
            run_word($urandom, 4'($urandom), "R4 random word after re-release");
        end
        run_word(32'h0, 4'h0, "R6 last word");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule